// File: doc/BRIEF.md
# First-Word Fall-Through Synchronous FIFO

This block is a single-clock first-in first-out buffer that sits between a producer and a consumer. The producer offers a word with a push request; the word is stored if there is room. The consumer always sees the oldest stored word on the head output, with no request and no wait cycle. It raises a pop request to step past that word to the next one.

Room and contents are tracked by a write pointer and a read pointer. Each pointer is one bit wider than the storage address. The low bits of a pointer select a slot. The extra top bit flips each time the pointer completes a lap of the storage. Equal pointers mean the buffer is empty. Pointers that select the same slot but sit on different laps mean the buffer is full.

Only the pointers are reset. The storage words are not reset, because the pointer logic never presents a slot that has not been written as the head word. The depth must be a power of two, so that binary wrap of the pointers matches wrap of the storage. This is checked at elaboration.

Top module: `fwft_fifo`

## Requirements
- R1: While the active-low reset input is low, both pointers are cleared at once, without waiting for a clock edge. The buffer then reports empty = 1 and full = 0.
- R2: Once a word has been pushed into an empty buffer, it appears on the head output after the next rising edge, with no pop request needed.
- R3: Words leave the buffer in the same order in which they were accepted. No word is lost and none is duplicated.
- R4: The full flag is 1 exactly when DEPTH words are held, and the empty flag is 1 exactly when no word is held. The two flags are never 1 together.
- R5: A push request while full is ignored. The stored words and the head output are unchanged, and the rejected word never appears on the head output.
- R6: A pop request while empty is ignored. The next word pushed afterwards becomes the head word.
- R7: A push and a pop that both take effect in the same cycle advance both pointers. The number of held words stays the same.
- R8: Ordering and flags stay correct across many wraps of the pointers through the storage.
- R9: When push and pop are requested together, the pop is ignored if the buffer is empty and the push is ignored if the buffer is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of both pointers |
| push_req | input | 1 | Request to store push_word |
| push_word | input | WIDTH | Word offered by the producer |
| is_full | output | 1 | All DEPTH slots hold unread words |
| pop_req | input | 1 | Request to step past the current head word |
| head_word | output | WIDTH | Oldest stored word, driven combinationally |
| is_empty | output | 1 | No unread word is held |

## Verification
A small instance with a depth of four is driven cycle by cycle. A reference queue in the bench predicts both flags and the head word at every step.

Directed sequences exercise specific boundaries:
- filling to full separates the lap-bit full test from the empty test;
- pushing against full and popping against empty show that rejected requests leave no trace;
- concurrent push and pop at empty, half and full show which side wins at each boundary.

An exhaustive pass then applies every four-cycle sequence of the two request bits. A long run follows with fill-heavy, drain-heavy, always-both and irregular request mixes. Together these drive the pointers through many laps, so a fault in wrap handling or in the top-bit comparison shows up as a wrong flag or a word out of order.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

   typedef enum logic [0:0] {
      STORE_ARRAY = 1'b0,
      STORE_SLOTS = 1'b1
   } store_style_e;

   function automatic bit depth_ok(input int unsigned d);
      return (d >= 2) && ((d & (d - 1)) == 0);
   endfunction

endpackage

// File: rtl/fwft_ptr.sv
module fwft_ptr #(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   output logic [AW:0]   ptr
);
   localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= ptr + ONE;
      end
   end
endmodule

// File: rtl/fwft_flags.sv
module fwft_flags #(
   parameter int unsigned AW = 3
) (
   input  logic [AW:0] wr_ptr,
   input  logic [AW:0] rd_ptr,
   output logic        full,
   output logic        empty
);
   logic same_slot;
   logic same_lap;

   always_comb begin
      same_slot = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
      same_lap  = (wr_ptr[AW] == rd_ptr[AW]);
      empty     = same_slot && same_lap;
      full      = same_slot && !same_lap;
   end
endmodule

// File: rtl/fwft_store.sv
module fwft_store
   import fwft_pkg::*;
#(
   parameter int unsigned  WIDTH = 8,
   parameter int unsigned  DEPTH = 8,
   parameter store_style_e STYLE = STORE_ARRAY,
   localparam int unsigned AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] slot_q [DEPTH];

   generate
      if (STYLE == STORE_ARRAY) begin : g_array
         always_ff @(posedge clk) begin
            if (we) begin
               slot_q[waddr] <= wdata;
            end
         end
      end else begin : g_slots
         for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            logic hit;
            assign hit = we && (waddr == AW'(s));
            always_ff @(posedge clk) begin
               if (hit) begin
                  slot_q[s] <= wdata;
               end
            end
         end
      end
   endgenerate

   assign rdata = slot_q[raddr];
endmodule

// File: rtl/fwft_fifo.sv
module fwft_fifo
   import fwft_pkg::*;
#(
   parameter int unsigned  WIDTH = 8,
   parameter int unsigned  DEPTH = 8,
   parameter store_style_e STYLE = STORE_ARRAY
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_req,
   input  logic [WIDTH-1:0] push_word,
   output logic             is_full,
   input  logic             pop_req,
   output logic [WIDTH-1:0] head_word,
   output logic             is_empty
);
   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (!depth_ok(DEPTH)) begin : g_bad_depth
         $error("fwft_fifo: DEPTH must be a power of two and at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("fwft_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic [AW:0] wr_ptr;
   logic [AW:0] rd_ptr;
   logic        push_go;
   logic        pop_go;

   assign push_go = push_req && !is_full;
   assign pop_go  = pop_req && !is_empty;

   fwft_ptr #(.AW(AW)) wr_ptr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (push_go),
      .ptr   (wr_ptr)
   );

   fwft_ptr #(.AW(AW)) rd_ptr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (pop_go),
      .ptr   (rd_ptr)
   );

   fwft_flags #(.AW(AW)) flags_i (
      .wr_ptr (wr_ptr),
      .rd_ptr (rd_ptr),
      .full   (is_full),
      .empty  (is_empty)
   );

   fwft_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STYLE(STYLE)) store_i (
      .clk   (clk),
      .we    (push_go),
      .waddr (wr_ptr[AW-1:0]),
      .wdata (push_word),
      .raddr (rd_ptr[AW-1:0]),
      .rdata (head_word)
   );
endmodule

// File: rtl/fwft_fifo_chk.sv
module fwft_fifo_chk #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_req,
   input logic             pop_req,
   input logic             is_full,
   input logic             is_empty,
   input logic [WIDTH-1:0] head_word
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   logic [AW:0] held;
   logic        acc_push;
   logic        acc_pop;

   assign acc_push = push_req && !is_full;
   assign acc_pop  = pop_req && !is_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held <= '0;
      end else begin
         held <= held + (AW+1)'(acc_push) - (AW+1)'(acc_pop);
      end
   end

   // R1: flags while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_flags_R1: assert (is_empty && !is_full);
      end
   end

   // R4
   assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_full && is_empty));

   // R4 / R7: flags agree with a count of accepted transfers
   assert_empty_matches_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty == (held == '0));

   assert_full_matches_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_full == (held == FULL_CNT));

   // R5
   assert_full_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && !pop_req) |=> is_full);

   // R6
   assert_empty_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (is_empty && !push_req) |=> is_empty);

   // R2 / R3: head word only changes on a pop
   assert_head_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_empty && !pop_req) |=> $stable(head_word));
endmodule

bind fwft_fifo fwft_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .push_req  (push_req),
   .pop_req   (pop_req),
   .is_full   (is_full),
   .is_empty  (is_empty),
   .head_word (head_word)
);

// File: tb/fwft_fifo_tb_top.sv
module fwft_fifo_tb_top;
   localparam int unsigned W = 8;
   localparam int unsigned D = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic         push_req = 1'b0;
   logic [W-1:0] push_word = '0;
   logic         pop_req = 1'b0;
   logic         is_full;
   logic         is_empty;
   logic [W-1:0] head_word;

   int n_cmp = 0;
   int n_bad = 0;
   int seq = 0;
   bit done = 1'b0;

   logic [W-1:0] m_q [D];
   int m_rd = 0;
   int m_cnt = 0;

   always #5 clk = ~clk;

   fwft_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req),
      .push_word (push_word),
      .is_full   (is_full),
      .pop_req   (pop_req),
      .head_word (head_word),
      .is_empty  (is_empty)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Check outputs, apply requests, advance the reference queue.
   task automatic step(input logic p, input logic q, input string tag);
      logic [W-1:0] d;
      bit pw;
      bit pr;
      @(negedge clk);
      cmp(tag, "is_empty", int'(is_empty), int'(m_cnt == 0));
      cmp(tag, "is_full", int'(is_full), int'(m_cnt == D));
      if (m_cnt != 0) begin
         cmp(tag, "head_word", int'(head_word), int'(m_q[m_rd]));
      end
      d = W'(seq * 37 + 11);
      seq++;
      push_req = p;
      pop_req = q;
      push_word = d;
      pw = p && (m_cnt != D);
      pr = q && (m_cnt != 0);
      if (pw) m_q[(m_rd + m_cnt) % D] = d;
      if (pr) m_rd = (m_rd + 1) % D;
      m_cnt = m_cnt + int'(pw) - int'(pr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #2 rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: flags right after reset
      cmp("R1", "is_empty", int'(is_empty), 1);
      cmp("R1", "is_full", int'(is_full), 0);

      // R2: a single word falls through to the head output
      step(1, 0, "R2");
      step(0, 0, "R2");
      step(0, 0, "R2");

      // R4: fill up to full, then R5: push against full is ignored
      for (int i = 0; i < D; i++) step(1, 0, "R4");
      step(1, 0, "R5");
      step(1, 0, "R5");
      step(0, 0, "R5");
      // R3: drain everything in order
      for (int i = 0; i < D + 1; i++) step(0, 1, "R3");

      // R6: pop against empty is ignored, next push becomes the head
      step(0, 1, "R6");
      step(0, 1, "R6");
      step(1, 0, "R6");
      step(0, 0, "R6");

      // R7: concurrent push and pop at a middle level
      step(1, 0, "R7");
      for (int i = 0; i < 6; i++) step(1, 1, "R7");
      step(0, 0, "R7");

      // R9: concurrent at full (push ignored) and at empty (pop ignored)
      for (int i = 0; i < D; i++) step(1, 0, "R9");
      step(1, 1, "R9");
      step(1, 0, "R9");
      for (int i = 0; i < D; i++) step(0, 1, "R9");
      step(1, 1, "R9");
      step(0, 0, "R9");

      // R9: every four-cycle sequence of the two request bits
      for (int s = 0; s < 256; s++) begin
         for (int k = 0; k < 4; k++) begin
            int b;
            b = (s >> (2 * k)) & 3;
            step(b[0], b[1], "R9");
         end
      end

      // R8: long mixed traffic across many pointer laps
      for (int i = 0; i < 4000; i++) begin
         logic p;
         logic q;
         case (i / 1000)
            0: begin p = (i % 4) != 3; q = (i % 3) == 0; end
            1: begin p = (i % 3) == 0; q = (i % 4) != 3; end
            2: begin p = 1'b1; q = 1'b1; end
            default: begin p = ((i * 13) % 11) < 6; q = ((i * 7) % 9) < 5; end
         endcase
         step(p, q, "R8");
      end
      step(0, 0, "R8");

      // R1: reset taken without a clock edge
      for (int i = 0; i < 2; i++) step(1, 0, "R1");
      @(negedge clk);
      push_req = 1'b0;
      pop_req = 1'b0;
      #2 rst_n = 1'b0;
      #1;
      cmp("R1", "is_empty async", int'(is_empty), 1);
      cmp("R1", "is_full async", int'(is_full), 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_rd = 0;
      m_cnt = 0;
      step(1, 0, "R1");
      step(0, 0, "R1");
      step(0, 0, "R1");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule